// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the hazard controller for an in-order integer pipeline with fetch, decode, execute, memory and write-back stages. Operands are read only in decode and results are written only in write-back, so the only dependences it must handle are reads of a value that an older instruction has not yet written back. It looks at the register numbers, write enables and load flags held in the pipeline registers. From these it picks where each operand comes from, holds the front of the pipe, turns the next execute slot into a bubble, and clears a wrongly fetched instruction after a taken branch.

The ALU operand selects for execute are worked out one stage early, while the consumer is still in decode, and are then registered into the execute stage. The consumer's producers shift along in step, so the values stay valid when the consumer reaches execute. Branches are resolved in decode, so decode has its own operand selects. These cover a same-cycle write-back bypass and a forward from the memory-stage ALU result. A branch waits when its operand is not ready yet. Fetch always assumes a branch is not taken. A taken branch costs one squashed slot.

Top module: `hazard_unit`

## Requirements
- R1: A select value is 2 for the memory-stage result, 1 for the write-back-stage result and 0 for the register file. `ex_fwd_a`/`ex_fwd_b` is 2 when the instruction in execute reads a source that the instruction in memory writes. This holds even if write-back also writes that register.
- R2: `ex_fwd_a`/`ex_fwd_b` is 1 when only the write-back instruction writes the used source. It is 0 when no older in-flight instruction writes it, or when that source is marked unused.
- R3: Register 0 never produces a forward, a decode select, or a stall.
- R4: A load in execute whose destination is a used source of a non-branch instruction in decode raises `front_hold` and `idex_bubble` for exactly one cycle.
- R5: In the cycle after a stall, the bubble in execute carries `ex_fwd_a` = `ex_fwd_b` = 0.
- R6: A branch in decode stalls while any writer in execute targets one of its used sources. It also stalls while a load in memory targets one of its used sources.
- R7: `ifid_flush` is 1 exactly when decode holds a branch marked taken and no stall is raised.
- R8: `id_sel_a`/`id_sel_b` is 2 when a non-load in memory writes the used source. It is 0 when a load in memory writes that source. It is 1 when only write-back writes it, which is the same-cycle bypass. It is 0 otherwise.
- R9: While reset is held, `ex_fwd_a` and `ex_fwd_b` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| id_rs1 | input | REG_W | first source register of the decode instruction |
| id_rs2 | input | REG_W | second source register of the decode instruction |
| id_rs1_used | input | 1 | decode instruction reads its first source |
| id_rs2_used | input | 1 | decode instruction reads its second source |
| id_is_branch | input | 1 | decode instruction is a conditional branch |
| id_br_taken | input | 1 | branch resolved in decode as taken |
| ex_rd | input | REG_W | destination register of the execute instruction |
| ex_wr_en | input | 1 | execute instruction writes a register |
| ex_is_load | input | 1 | execute instruction is a load |
| mem_rd | input | REG_W | destination register of the memory instruction |
| mem_wr_en | input | 1 | memory instruction writes a register |
| mem_is_load | input | 1 | memory instruction is a load |
| wb_rd | input | REG_W | destination register of the write-back instruction |
| wb_wr_en | input | 1 | write-back instruction writes a register |
| front_hold | output | 1 | hold PC and the fetch/decode register |
| idex_bubble | output | 1 | load a no-op into decode/execute |
| ifid_flush | output | 1 | clear the fetch/decode register |
| id_sel_a | output | 2 | decode operand A source |
| id_sel_b | output | 2 | decode operand B source |
| ex_fwd_a | output | 2 | execute operand A source (registered) |
| ex_fwd_b | output | 2 | execute operand B source (registered) |

## Verification
Some properties are checked on every cycle by assertions. Register 0 never causes a stall or forward. A stall always leaves clean selects in execute. Unused sources never forward. A load in memory is never chosen as a decode forward. A flush never coincides with a hold. Other behaviour can only be shown by the bench, which runs instruction streams through a behavioural pipeline model. That covers the length of each interlock, meaning one bubble for load-use and two for a load feeding a branch. It also covers the memory-over-write-back priority and the squash after a taken branch.

// File: rtl/hz_pkg.sv
// Shared encodings for the hazard controller.
// Assumes a two-bit operand source select is enough for three sources.
package hz_pkg;
    typedef enum logic [1:0] {
        SRC_REGFILE = 2'd0,
        SRC_WB      = 2'd1,
        SRC_MEM     = 2'd2
    } src_sel_e;
endpackage

// File: rtl/hz_reg_match.sv
// Compares one consumer source register with one producer destination.
// Assumes register 0 is hard-wired and never carries a dependence.
module hz_reg_match #(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic             src_used,
    input  logic [REG_W-1:0] dst,
    input  logic             dst_wr,
    output logic             hit
);
    // a real dependence needs a used source, a writing producer and a nonzero register
    always_comb begin
        hit = src_used && dst_wr && (dst != '0) && (src == dst);
    end
endmodule

// File: rtl/hz_interlock.sv
// Decides front-end hold, execute bubble and fetch squash.
// Assumes branches resolve in decode and fetch predicts not taken.
module hz_interlock #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            id_is_branch,
    input  logic            id_br_taken,
    input  logic            ex_is_load,
    input  logic            mem_is_load,
    input  logic [NSRC-1:0] hit_ex,
    input  logic [NSRC-1:0] hit_mem,
    output logic            stall_o,
    output logic            flush_o
);
    logic load_use;
    logic branch_wait;

    // load result is not available to the next instruction in time
    always_comb begin
        load_use = ex_is_load && (|hit_ex);
    end

    // decode-stage compare needs its operand from execute or from a pending load
    always_comb begin
        branch_wait = id_is_branch && ((|hit_ex) || (mem_is_load && (|hit_mem)));
    end

    // combine stall causes and squash the wrong-path fetch
    always_comb begin
        stall_o = load_use || branch_wait;
        flush_o = id_is_branch && id_br_taken && !stall_o;
    end

    // R6: with no producer match there is nothing to wait for
    assert_no_hit_no_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_ex == '0) && (hit_mem == '0)) |-> !stall_o)
        else $error("stall without producer match");
endmodule

// File: rtl/hz_id_select.sv
// Chooses decode-stage operand sources for the branch comparator.
// Assumes the memory-stage ALU result is available by the end of the cycle.
module hz_id_select
    import hz_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mem_is_load,
    input  logic [NSRC-1:0]      hit_mem,
    input  logic [NSRC-1:0]      hit_wb,
    output logic [NSRC-1:0][1:0] sel_o
);
    for (genvar g = 0; g < NSRC; g++) begin : g_op
        // younger memory-stage writer wins; a pending load blocks the older copy
        always_comb begin
            if (hit_mem[g]) begin
                sel_o[g] = mem_is_load ? SRC_REGFILE : SRC_MEM;
            end else if (hit_wb[g]) begin
                sel_o[g] = SRC_WB;
            end else begin
                sel_o[g] = SRC_REGFILE;
            end
        end

        // R8: load data is never taken from the memory-stage ALU path
        assert_load_never_id_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
            mem_is_load |-> (sel_o[g] != SRC_MEM))
            else $error("load forwarded to decode");
    end
endmodule

// File: rtl/hz_fwd_stage.sv
// Computes execute operand selects one stage early and registers them.
// Assumes producers in execute/memory move to memory/write-back next cycle.
module hz_fwd_stage
    import hz_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stall_i,
    input  logic [NSRC-1:0]      id_used,
    input  logic [NSRC-1:0]      hit_ex,
    input  logic [NSRC-1:0]      hit_mem,
    output logic [NSRC-1:0][1:0] fwd_o
);
    for (genvar g = 0; g < NSRC; g++) begin : g_op
        logic [1:0] fwd_next;

        // next-cycle position of the nearest older writer
        always_comb begin
            if (hit_ex[g]) begin
                fwd_next = SRC_MEM;
            end else if (hit_mem[g]) begin
                fwd_next = SRC_WB;
            end else begin
                fwd_next = SRC_REGFILE;
            end
        end

        // register the select; a bubble entering execute gets the register file
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fwd_o[g] <= SRC_REGFILE;
            end else if (stall_i) begin
                fwd_o[g] <= SRC_REGFILE;
            end else begin
                fwd_o[g] <= fwd_next;
            end
        end

        // R5: a bubble inserted by a stall carries no forward
        assert_bubble_clears_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(stall_i) |-> (fwd_o[g] == SRC_REGFILE))
            else $error("bubble carries forward");

        // R2: an unused source is never forwarded
        assert_unused_src_no_fwd_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $past(!id_used[g]) |-> (fwd_o[g] == SRC_REGFILE))
            else $error("unused source forwarded");
    end
endmodule

// File: rtl/hazard_unit.sv
// Hazard controller top: dependence matching, interlock, decode and execute selects.
// Assumes operands read in decode, results written in write-back, in-order issue.
module hazard_unit
    import hz_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] id_rs1,
    input  logic [REG_W-1:0] id_rs2,
    input  logic             id_rs1_used,
    input  logic             id_rs2_used,
    input  logic             id_is_branch,
    input  logic             id_br_taken,
    input  logic [REG_W-1:0] ex_rd,
    input  logic             ex_wr_en,
    input  logic             ex_is_load,
    input  logic [REG_W-1:0] mem_rd,
    input  logic             mem_wr_en,
    input  logic             mem_is_load,
    input  logic [REG_W-1:0] wb_rd,
    input  logic             wb_wr_en,
    output logic             front_hold,
    output logic             idex_bubble,
    output logic             ifid_flush,
    output logic [1:0]       id_sel_a,
    output logic [1:0]       id_sel_b,
    output logic [1:0]       ex_fwd_a,
    output logic [1:0]       ex_fwd_b
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_W-1:0] id_src;
    logic [NSRC-1:0]            id_used;
    logic [NSRC-1:0]            hit_ex;
    logic [NSRC-1:0]            hit_mem;
    logic [NSRC-1:0]            hit_wb;
    logic [NSRC-1:0][1:0]       id_sel;
    logic [NSRC-1:0][1:0]       ex_fwd;
    logic                       stall;
    logic                       flush;

    // gather decode sources into indexable vectors
    always_comb begin
        id_src  = {id_rs2, id_rs1};
        id_used = {id_rs2_used, id_rs1_used};
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_match
        hz_reg_match #(.REG_W(REG_W)) u_ex (
            .src(id_src[g]), .src_used(id_used[g]),
            .dst(ex_rd), .dst_wr(ex_wr_en), .hit(hit_ex[g]));
        hz_reg_match #(.REG_W(REG_W)) u_mem (
            .src(id_src[g]), .src_used(id_used[g]),
            .dst(mem_rd), .dst_wr(mem_wr_en), .hit(hit_mem[g]));
        hz_reg_match #(.REG_W(REG_W)) u_wb (
            .src(id_src[g]), .src_used(id_used[g]),
            .dst(wb_rd), .dst_wr(wb_wr_en), .hit(hit_wb[g]));
    end

    hz_interlock #(.NSRC(NSRC)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
        .ex_is_load(ex_is_load), .mem_is_load(mem_is_load),
        .hit_ex(hit_ex), .hit_mem(hit_mem),
        .stall_o(stall), .flush_o(flush));

    hz_id_select #(.NSRC(NSRC)) u_idsel (
        .clk(clk), .rst_n(rst_n),
        .mem_is_load(mem_is_load),
        .hit_mem(hit_mem), .hit_wb(hit_wb),
        .sel_o(id_sel));

    hz_fwd_stage #(.NSRC(NSRC)) u_fwd (
        .clk(clk), .rst_n(rst_n),
        .stall_i(stall), .id_used(id_used),
        .hit_ex(hit_ex), .hit_mem(hit_mem),
        .fwd_o(ex_fwd));

    // drive the output ports
    always_comb begin
        front_hold  = stall;
        idex_bubble = stall;
        ifid_flush  = flush;
        id_sel_a    = id_sel[0];
        id_sel_b    = id_sel[1];
        ex_fwd_a    = ex_fwd[0];
        ex_fwd_b    = ex_fwd[1];
    end

    // R3: register 0 producers never cause a stall
    assert_zero_reg_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((ex_rd == '0) && (mem_rd == '0)) |-> !front_hold)
        else $error("stall on register 0");

    // R3: register 0 producers never cause an execute forward
    assert_zero_reg_no_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past((ex_rd == '0) && (mem_rd == '0)) |-> ((ex_fwd_a == SRC_REGFILE) && (ex_fwd_b == SRC_REGFILE)))
        else $error("forward on register 0");

    // R7: squash only for a taken branch that is not held
    assert_flush_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |-> (!front_hold && id_is_branch && id_br_taken))
        else $error("bad flush");
endmodule

// File: tb/hazard_unit_tb.sv
`timescale 1ns/1ps
module hazard_unit_tb;
    typedef struct {
        int rd; int rs1; int rs2;
        bit u1; bit u2; bit wr; bit ld; bit br; bit tk;
    } ins_t;

    logic clk = 0;
    logic rst_n = 0;
    logic [4:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
    logic id_rs1_used, id_rs2_used, id_is_branch, id_br_taken;
    logic ex_wr_en, ex_is_load, mem_wr_en, mem_is_load, wb_wr_en;
    logic front_hold, idex_bubble, ifid_flush;
    logic [1:0] id_sel_a, id_sel_b, ex_fwd_a, ex_fwd_b;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    hazard_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
        .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
        .ex_rd(ex_rd), .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load),
        .wb_rd(wb_rd), .wb_wr_en(wb_wr_en),
        .front_hold(front_hold), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush),
        .id_sel_a(id_sel_a), .id_sel_b(id_sel_b), .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b));

    ins_t prog[$];
    ins_t s_id, s_ex, s_mem, s_wb;
    int pc = 0;
    bit ex_from_stall = 0;
    bit cur_stall, cur_flush;
    int run = 0;
    bit run_br = 0;

    function automatic ins_t mk(int d, int a, int b, bit u1, bit u2, bit wr, bit ld, bit br, bit tk);
        ins_t t;
        t.rd = d; t.rs1 = a; t.rs2 = b; t.u1 = u1; t.u2 = u2;
        t.wr = wr; t.ld = ld; t.br = br; t.tk = tk;
        return t;
    endfunction

    function automatic ins_t nop();
        return mk(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endfunction

    function automatic bit dep(int src, bit used, ins_t p);
        return used && p.wr && p.rd != 0 && src == p.rd;
    endfunction

    function automatic bit any_dep(ins_t c, ins_t p);
        return dep(c.rs1, c.u1, p) || dep(c.rs2, c.u2, p);
    endfunction

    function automatic int exp_id_sel(int src, bit used);
        if (dep(src, used, s_mem)) return s_mem.ld ? 0 : 2;
        if (dep(src, used, s_wb)) return 1;
        return 0;
    endfunction

    function automatic int exp_ex_fwd(int src, bit used);
        if (dep(src, used, s_mem)) return 2;
        if (dep(src, used, s_wb)) return 1;
        return 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive();
        id_rs1 = 5'(s_id.rs1); id_rs2 = 5'(s_id.rs2);
        id_rs1_used = s_id.u1; id_rs2_used = s_id.u2;
        id_is_branch = s_id.br; id_br_taken = s_id.tk;
        ex_rd = 5'(s_ex.rd); ex_wr_en = s_ex.wr; ex_is_load = s_ex.ld;
        mem_rd = 5'(s_mem.rd); mem_wr_en = s_mem.wr; mem_is_load = s_mem.ld;
        wb_rd = 5'(s_wb.rd); wb_wr_en = s_wb.wr;
    endtask

    function automatic string ex_tag(int src, bit used, int e);
        if (used && src == 0) return "R3";
        if (ex_from_stall) return "R5";
        if (e == 2) return "R1";
        return "R2";
    endfunction

    task automatic compare();
        int e;
        string tg;
        cur_stall = (s_ex.ld && any_dep(s_id, s_ex)) ||
                    (s_id.br && (any_dep(s_id, s_ex) || (s_mem.ld && any_dep(s_id, s_mem))));
        cur_flush = s_id.br && s_id.tk && !cur_stall;
        tg = s_id.br ? "R6" : "R4";
        if ((s_id.u1 && s_id.rs1 == 0) || (s_id.u2 && s_id.rs2 == 0)) tg = "R3";
        chk(front_hold == cur_stall, tg, front_hold, cur_stall);
        chk(idex_bubble == cur_stall, tg, idex_bubble, cur_stall);
        chk(ifid_flush == cur_flush, "R7", ifid_flush, cur_flush);
        e = exp_id_sel(s_id.rs1, s_id.u1);
        chk(id_sel_a == 2'(e), (s_id.u1 && s_id.rs1 == 0) ? "R3" : "R8", id_sel_a, e);
        e = exp_id_sel(s_id.rs2, s_id.u2);
        chk(id_sel_b == 2'(e), (s_id.u2 && s_id.rs2 == 0) ? "R3" : "R8", id_sel_b, e);
        e = exp_ex_fwd(s_ex.rs1, s_ex.u1);
        chk(ex_fwd_a == 2'(e), ex_tag(s_ex.rs1, s_ex.u1, e), ex_fwd_a, e);
        e = exp_ex_fwd(s_ex.rs2, s_ex.u2);
        chk(ex_fwd_b == 2'(e), ex_tag(s_ex.rs2, s_ex.u2, e), ex_fwd_b, e);
        // R4: a load-use interlock lasts exactly one cycle
        if (cur_stall) begin
            run++;
            run_br |= s_id.br;
        end else if (run > 0) begin
            if (!run_br) chk(run == 1, "R4", run, 1);
            run = 0;
            run_br = 0;
        end
    endtask

    task automatic advance();
        s_wb = s_mem;
        s_mem = s_ex;
        if (cur_stall) begin
            s_ex = nop();
            ex_from_stall = 1;
        end else begin
            s_ex = s_id;
            ex_from_stall = 0;
            if (cur_flush) begin
                s_id = nop();
                pc++;
            end else begin
                s_id = (pc < prog.size()) ? prog[pc] : nop();
                pc++;
            end
        end
    endtask

    task automatic alu(int d, int a, int b);
        prog.push_back(mk(d, a, b, 1, 1, 1, 0, 0, 0));
    endtask
    task automatic load(int d, int a);
        prog.push_back(mk(d, a, 0, 1, 0, 1, 1, 0, 0));
    endtask
    task automatic branch(int a, int b, bit tk);
        prog.push_back(mk(0, a, b, 1, 1, 0, 0, 1, tk));
    endtask
    task automatic bubble();
        prog.push_back(nop());
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1 and R2: forwarding priority
        alu(1, 2, 3); alu(4, 1, 5); alu(6, 7, 1);
        alu(1, 8, 9); alu(1, 10, 11); alu(12, 1, 1);
        // R4 and R5: load-use bubble
        load(13, 2); alu(14, 13, 3);
        load(15, 2); bubble(); alu(16, 15, 15);
        // R3: register 0
        alu(0, 1, 2); alu(17, 0, 0);
        load(0, 3); alu(18, 0, 4);
        // R8: same-cycle write-back bypass into decode
        alu(19, 1, 2); bubble(); bubble(); alu(20, 19, 19);
        // R6 and R7: branch waits on execute writer, then taken squash
        alu(21, 1, 2); branch(21, 3, 1); alu(22, 1, 1);
        // R6: branch on a load waits two cycles
        load(23, 1); branch(23, 0, 0);
        // R8 and R7: branch takes memory-stage ALU result, taken
        alu(24, 1, 2); alu(25, 3, 4); branch(24, 5, 1); alu(26, 24, 24);
        // R2: unused second source with a matching register number
        alu(27, 1, 2); prog.push_back(mk(28, 3, 27, 1, 0, 1, 0, 0, 0));
        alu(29, 28, 27);

        s_id = nop(); s_ex = nop(); s_mem = nop(); s_wb = nop();
        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(ex_fwd_a == 2'd0, "R9", ex_fwd_a, 0);
        chk(ex_fwd_b == 2'd0, "R9", ex_fwd_b, 0);
        rst_n = 1;
        for (int cyc = 0; cyc < 70; cyc++) begin
            @(negedge clk);
            drive();
            #1;
            compare();
            @(posedge clk);
            #1;
            advance();
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule